// File: doc/BRIEF.md
# Compact Sixteen-Bit Register-Machine Core

This core executes one instruction per clock from a 256-word program held outside the block. It drives an 8-bit fetch address and takes back a 27-bit instruction word in the same cycle. The instruction memory is read combinationally. A register write, flag update or program-counter load for that word takes effect at the next rising edge. The core has eight 16-bit general registers, a zero flag and an 8-bit program counter. It has no data memory, so a program works only on registers and immediates.

Three instruction formats are decoded. Register-register and register-immediate ALU operations share one operator code set. A third format holds increment, decrement, no-op, both forms of move, and two absolute jumps. A debug port lets the surrounding logic read any register combinationally, which is how a test harness or a monitor observes results.

Top module: `rmc_core`

## Requirements
- R1: While reset is high at a clock edge, the program counter, all eight registers and the zero flag are cleared. The fetch address is 0 in the first cycle after reset falls.
- R2: An instruction other than a taken jump advances the fetch address by one. Address 255 is followed by 0.
- R3: The word holds, from bit 26 down, a format field [26:25], an operator [24:22], a destination [21:19], source A [18:16] and a 16-bit immediate [15:0]. Source B is [15:13] of the immediate field. With format 00, operators 0..6 write the destination with A+B, A-B, A>>B, A<<B, A&B, A|B and A^B.
- R4: With format 01, the same operators 0..6 combine source A with the immediate. For the two shifts, the immediate is the shift count.
- R5: Sums and differences wrap modulo 2^16. A shift count of 16 or more yields 0.
- R6: Format 10 operator 0 adds one to the destination register and operator 1 subtracts one from it, both wrapping.
- R7: Format 10 operator 3 writes the immediate to the destination. Operator 4 copies source A to the destination.
- R8: Format 10 operator 5 sets the next fetch address to immediate bits [7:0] and ignores immediate bits [15:8].
- R9: Format 10 operator 6 jumps to immediate bits [7:0] only when the zero flag is set. Otherwise it falls through to the next address.
- R10: Format 00/01 ALU operations and format 10 increment/decrement set the zero flag exactly when the value they write is 0. Moves, no-ops and jumps leave the flag unchanged.
- R11: Format 10 operator 2, operator 7 in any format, and every format 11 word change no register and no flag.
- R12: The debug output shows the register selected by the debug index, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imemAddr | output | 8 | Fetch address (program counter) |
| imemData | input | 27 | Instruction word at imemAddr, same cycle |
| dbgSel | input | 3 | Register index for the debug read |
| dbgData | output | 16 | Contents of the selected register |

## Verification
On every cycle the assertions check how the program counter moves: a step of one with wrap, jump targets taken from the low immediate byte, and the jump-if-zero decision against the flag. They also check that the flag is cleared by reset and held across every instruction that may not write it. ALU results, wrap-around, shift saturation, moves, increment and decrement, and the fact that ignored encodings leave registers untouched depend on data values. Only the bench's directed programs can show these, reading registers back through the debug port.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  localparam logic [1:0] FMT_REG = 2'b00;
  localparam logic [1:0] FMT_IMM = 2'b01;
  localparam logic [1:0] FMT_SPC = 2'b10;

  localparam logic [2:0] OP_RSVD = 3'd7;

  localparam logic [2:0] SPC_INC  = 3'd0;
  localparam logic [2:0] SPC_DEC  = 3'd1;
  localparam logic [2:0] SPC_MOVI = 3'd3;
  localparam logic [2:0] SPC_MOVR = 3'd4;
  localparam logic [2:0] SPC_JMP  = 3'd5;
  localparam logic [2:0] SPC_JMPZ = 3'd6;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_SHR = 3'd2,
    ALU_SHL = 3'd3,
    ALU_AND = 3'd4,
    ALU_OR  = 3'd5,
    ALU_XOR = 3'd6,
    ALU_NOP = 3'd7
  } aluOp_e;

  typedef enum logic [1:0] {
    OPB_REG = 2'd0,
    OPB_IMM = 2'd1,
    OPB_ONE = 2'd2
  } opbSel_e;

  typedef enum logic [1:0] {
    WB_ALU  = 2'd0,
    WB_IMM  = 2'd1,
    WB_REGA = 2'd2
  } wbSel_e;

  typedef struct packed {
    logic    regWr;
    logic    flagWr;
    logic    aFromDest;
    opbSel_e opbSel;
    aluOp_e  aluOp;
    wbSel_e  wbSel;
    logic    pcLoad;
  } ctrl_t;

endpackage

// File: rtl/rmc_alu.sv
module rmc_alu
  import rmc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  aluOp_e            op,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);

  localparam int SHAMT_W = $clog2(DATA_W);

  logic              shiftOver;
  logic [SHAMT_W-1:0] shamt;

  // counts of DATA_W or more flush the operand (DATA_W is a power of two)
  assign shiftOver = |opB[DATA_W-1:SHAMT_W];
  assign shamt     = opB[SHAMT_W-1:0];

  always_comb begin
    case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_SHR: result = shiftOver ? '0 : (opA >> shamt);
      ALU_SHL: result = shiftOver ? '0 : (opA << shamt);
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_XOR: result = opA ^ opB;
      default: result = opA;
    endcase
  end

endmodule

// File: rtl/rmc_regfile.sv
module rmc_regfile #(
  parameter int DATA_W = 16,
  parameter int RID_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [RID_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [RID_W-1:0]  rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [RID_W-1:0]  rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [RID_W-1:0]  dbgIdx,
  output logic [DATA_W-1:0] dbgData
);

  localparam int REG_N = 1 << RID_W;

  logic [DATA_W-1:0] regVal [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : gReg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wrEn && (wrIdx == RID_W'(g))) begin
        q <= wrData;
      end
    end
    assign regVal[g] = q;
  end

  assign rdDataA = regVal[rdIdxA];
  assign rdDataB = regVal[rdIdxB];
  assign dbgData = regVal[dbgIdx];

endmodule

// File: rtl/rmc_datapath.sv
module rmc_datapath
  import rmc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RID_W  = 3,
  parameter int IMM_W  = 16,
  parameter int PC_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [RID_W-1:0]  rdIdx,
  input  logic [RID_W-1:0]  raIdx,
  input  logic [RID_W-1:0]  rbIdx,
  input  logic [IMM_W-1:0]  imm,
  input  logic [RID_W-1:0]  dbgIdx,
  output logic [PC_W-1:0]   pc,
  output logic              zeroFlag,
  output logic [DATA_W-1:0] dbgData
);

  logic [RID_W-1:0]  readIdxA;
  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regB;
  logic [DATA_W-1:0] immVal;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] aluOut;
  logic [DATA_W-1:0] wbData;

  // increment and decrement take the destination as their A operand
  assign readIdxA = ctrl.aFromDest ? rdIdx : raIdx;
  assign immVal   = DATA_W'(imm);

  always_comb begin
    case (ctrl.opbSel)
      OPB_IMM: operandB = immVal;
      OPB_ONE: operandB = DATA_W'(1);
      default: operandB = regB;
    endcase
  end

  rmc_regfile #(
    .DATA_W(DATA_W),
    .RID_W (RID_W)
  ) u_rf (
    .clk    (clk),
    .rst    (rst),
    .wrEn   (ctrl.regWr),
    .wrIdx  (rdIdx),
    .wrData (wbData),
    .rdIdxA (readIdxA),
    .rdDataA(regA),
    .rdIdxB (rbIdx),
    .rdDataB(regB),
    .dbgIdx (dbgIdx),
    .dbgData(dbgData)
  );

  rmc_alu #(
    .DATA_W(DATA_W)
  ) u_alu (
    .op    (ctrl.aluOp),
    .opA   (regA),
    .opB   (operandB),
    .result(aluOut)
  );

  always_comb begin
    case (ctrl.wbSel)
      WB_IMM:  wbData = immVal;
      WB_REGA: wbData = regA;
      default: wbData = aluOut;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      zeroFlag <= 1'b0;
    end else if (ctrl.flagWr) begin
      zeroFlag <= (wbData == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
    end else if (ctrl.pcLoad) begin
      pc <= imm[PC_W-1:0];
    end else begin
      pc <= pc + PC_W'(1);
    end
  end

endmodule

// File: rtl/rmc_control.sv
module rmc_control
  import rmc_pkg::*;
(
  input  logic [1:0] fmt,
  input  logic [2:0] op,
  input  logic       zeroFlag,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl        = '0;
    ctrl.opbSel = OPB_REG;
    ctrl.aluOp  = ALU_ADD;
    ctrl.wbSel  = WB_ALU;

    if ((fmt == FMT_REG || fmt == FMT_IMM) && op != OP_RSVD) begin
      ctrl.regWr  = 1'b1;
      ctrl.flagWr = 1'b1;
      ctrl.aluOp  = aluOp_e'(op);
      ctrl.opbSel = (fmt == FMT_IMM) ? OPB_IMM : OPB_REG;
    end else if (fmt == FMT_SPC) begin
      case (op)
        SPC_INC, SPC_DEC: begin
          ctrl.regWr     = 1'b1;
          ctrl.flagWr    = 1'b1;
          ctrl.aFromDest = 1'b1;
          ctrl.opbSel    = OPB_ONE;
          ctrl.aluOp     = (op == SPC_INC) ? ALU_ADD : ALU_SUB;
        end
        SPC_MOVI: begin
          ctrl.regWr = 1'b1;
          ctrl.wbSel = WB_IMM;
        end
        SPC_MOVR: begin
          ctrl.regWr = 1'b1;
          ctrl.wbSel = WB_REGA;
        end
        SPC_JMP:  ctrl.pcLoad = 1'b1;
        SPC_JMPZ: ctrl.pcLoad = zeroFlag;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/rmc_core.sv
module rmc_core
  import rmc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int RID_W  = 3,
  parameter int IMM_W  = 16,
  parameter int PC_W   = 8,
  localparam int INSTR_W = 2 + 3 + 2 * RID_W + IMM_W
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    imemAddr,
  input  logic [INSTR_W-1:0] imemData,
  input  logic [RID_W-1:0]   dbgSel,
  output logic [DATA_W-1:0]  dbgData
);

  ctrl_t            ctrl;
  logic             zeroFlag;
  logic [1:0]       fmt;
  logic [2:0]       op;
  logic [RID_W-1:0] rdIdx;
  logic [RID_W-1:0] raIdx;
  logic [RID_W-1:0] rbIdx;
  logic [IMM_W-1:0] imm;

  assign fmt   = imemData[INSTR_W-1 -: 2];
  assign op    = imemData[INSTR_W-3 -: 3];
  assign rdIdx = imemData[IMM_W+2*RID_W-1 -: RID_W];
  assign raIdx = imemData[IMM_W+RID_W-1 -: RID_W];
  assign rbIdx = imemData[IMM_W-1 -: RID_W];
  assign imm   = imemData[IMM_W-1:0];

  rmc_control u_ctl (
    .fmt     (fmt),
    .op      (op),
    .zeroFlag(zeroFlag),
    .ctrl    (ctrl)
  );

  rmc_datapath #(
    .DATA_W(DATA_W),
    .RID_W (RID_W),
    .IMM_W (IMM_W),
    .PC_W  (PC_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .rdIdx   (rdIdx),
    .raIdx   (raIdx),
    .rbIdx   (rbIdx),
    .imm     (imm),
    .dbgIdx  (dbgSel),
    .pc      (imemAddr),
    .zeroFlag(zeroFlag),
    .dbgData (dbgData)
  );

endmodule

// File: rtl/rmc_core_chk.sv
module rmc_core_chk #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pc,
  input logic [1:0]      fmtBits,
  input logic [2:0]      opBits,
  input logic [PC_W-1:0] target,
  input logic            zeroFlag
);

  logic isJmp;
  logic isJmpz;
  logic flagWriter;

  always_comb begin
    isJmp      = (fmtBits == 2'b10) && (opBits == 3'd5);
    isJmpz     = (fmtBits == 2'b10) && (opBits == 3'd6);
    flagWriter = ((fmtBits == 2'b00 || fmtBits == 2'b01) && opBits != 3'd7) ||
                 ((fmtBits == 2'b10) && (opBits == 3'd0 || opBits == 3'd1));
  end

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc == '0) && !zeroFlag); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(isJmp) && !($past(isJmpz) && $past(zeroFlag)))
      |-> pc == $past(pc) + PC_W'(1)); // R2

  AST_JMP_TARGET: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(isJmp)) |-> pc == $past(target)); // R8

  AST_JMPZ_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(isJmpz) && $past(zeroFlag)) |-> pc == $past(target)); // R9

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flagWriter)) |-> $stable(zeroFlag)); // R10

endmodule

bind rmc_core rmc_core_chk #(
  .PC_W(PC_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc      (imemAddr),
  .fmtBits (imemData[INSTR_W-1 -: 2]),
  .opBits  (imemData[INSTR_W-3 -: 3]),
  .target  (imemData[PC_W-1:0]),
  .zeroFlag(zeroFlag)
);

// File: tb/sim_rmc_core.sv
module sim_rmc_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  imemAddr;
  logic [26:0] imemData;
  logic [2:0]  dbgSel = 3'd0;
  logic [15:0] dbgData;

  logic [26:0] mem [256];

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign imemData = mem[imemAddr];

  rmc_core u0 (
    .clk     (clk),
    .rst     (rst),
    .imemAddr(imemAddr),
    .imemData(imemData),
    .dbgSel  (dbgSel),
    .dbgData (dbgData)
  );

  function automatic logic [26:0] rrI(input logic [2:0] op, input logic [2:0] rd,
                                      input logic [2:0] ra, input logic [2:0] rb);
    return {2'b00, op, rd, ra, rb, 13'd0};
  endfunction

  function automatic logic [26:0] riI(input logic [2:0] op, input logic [2:0] rd,
                                      input logic [2:0] ra, input logic [15:0] imm);
    return {2'b01, op, rd, ra, imm};
  endfunction

  function automatic logic [26:0] spI(input logic [2:0] op, input logic [2:0] rd,
                                      input logic [2:0] ra, input logic [15:0] imm);
    return {2'b10, op, rd, ra, imm};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic checkReg(input string req, input int idx, input logic [15:0] exp);
    dbgSel = 3'(idx);
    #1;
    check(req, $sformatf("r%0d", idx), 32'(dbgData), 32'(exp));
  endtask

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = spI(3'd2, 3'd0, 3'd0, 16'd0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    clearMem();
    for (int i = 0; i < 8; i++) mem[i] = spI(3'd3, 3'(i), 3'd0, 16'(16'h1111 * (i + 1)));
    mem[8] = riI(3'd1, 3'd0, 3'd0, 16'h1111);
    doReset();
    check("R1", "fetch address after release", 32'(imemAddr), 32'd0);
    run(9);
    checkReg("R7", 5, 16'h6666);
    mem[0] = spI(3'd6, 3'd0, 3'd0, 16'h0028);
    doReset();
    for (int i = 0; i < 8; i++) checkReg("R1", i, 16'h0000);
    run(1);
    check("R1", "flag cleared, jmpz falls through", 32'(imemAddr), 32'd1);
  endtask

  task automatic testImm();
    clearMem();
    mem[0] = spI(3'd3, 3'd1, 3'd0, 16'h00F0);
    mem[1] = riI(3'd0, 3'd2, 3'd1, 16'h0010);
    mem[2] = riI(3'd1, 3'd3, 3'd1, 16'h00F1);
    mem[3] = riI(3'd2, 3'd4, 3'd1, 16'd4);
    mem[4] = riI(3'd3, 3'd5, 3'd1, 16'd8);
    mem[5] = riI(3'd4, 3'd6, 3'd1, 16'h0030);
    mem[6] = riI(3'd5, 3'd7, 3'd1, 16'h0F00);
    mem[7] = riI(3'd6, 3'd0, 3'd1, 16'h00FF);
    doReset();
    run(8);
    checkReg("R4", 2, 16'h00F0 + 16'h0010);
    checkReg("R5", 3, 16'h00F0 - 16'h00F1);
    checkReg("R4", 4, 16'h00F0 >> 4);
    checkReg("R4", 5, 16'h00F0 << 8);
    checkReg("R4", 6, 16'h00F0 & 16'h0030);
    checkReg("R4", 7, 16'h00F0 | 16'h0F00);
    checkReg("R12", 0, 16'h00F0 ^ 16'h00FF);
  endtask

  task automatic testRegReg();
    clearMem();
    mem[0] = spI(3'd3, 3'd1, 3'd0, 16'h8001);
    mem[1] = spI(3'd3, 3'd2, 3'd0, 16'd3);
    mem[2] = spI(3'd3, 3'd3, 3'd0, 16'd20);
    mem[3] = rrI(3'd0, 3'd4, 3'd1, 3'd1);
    mem[4] = rrI(3'd1, 3'd5, 3'd2, 3'd1);
    mem[5] = rrI(3'd2, 3'd6, 3'd1, 3'd2);
    mem[6] = rrI(3'd3, 3'd7, 3'd1, 3'd3);
    mem[7] = rrI(3'd4, 3'd0, 3'd1, 3'd2);
    mem[8] = rrI(3'd5, 3'd2, 3'd1, 3'd2);
    mem[9] = rrI(3'd6, 3'd3, 3'd1, 3'd2);
    doReset();
    run(10);
    checkReg("R5", 4, 16'h0002);
    checkReg("R3", 5, 16'h8002);
    checkReg("R3", 6, 16'h1000);
    checkReg("R5", 7, 16'h0000);
    checkReg("R3", 0, 16'h0001);
    checkReg("R3", 2, 16'h8003);
    checkReg("R3", 3, 16'h0002);
  endtask

  task automatic testSpecial();
    clearMem();
    mem[0] = spI(3'd3, 3'd1, 3'd0, 16'hFFFF);
    mem[1] = spI(3'd0, 3'd1, 3'd5, 16'h0000);
    mem[2] = spI(3'd1, 3'd2, 3'd0, 16'h0000);
    mem[3] = spI(3'd4, 3'd3, 3'd2, 16'h0000);
    mem[4] = spI(3'd0, 3'd4, 3'd0, 16'h0000);
    mem[5] = spI(3'd3, 3'd5, 3'd0, 16'hA5C3);
    mem[6] = spI(3'd4, 3'd6, 3'd5, 16'h0000);
    mem[7] = riI(3'd3, 3'd7, 3'd5, 16'd15);
    mem[8] = riI(3'd2, 3'd0, 3'd7, 16'd15);
    mem[9] = riI(3'd2, 3'd7, 3'd7, 16'd16);
    doReset();
    run(10);
    checkReg("R6", 1, 16'h0000);
    checkReg("R6", 2, 16'hFFFF);
    checkReg("R7", 3, 16'hFFFF);
    checkReg("R6", 4, 16'h0001);
    checkReg("R7", 5, 16'hA5C3);
    checkReg("R7", 6, 16'hA5C3);
    checkReg("R5", 0, 16'h0001);
    checkReg("R5", 7, 16'h0000);
  endtask

  task automatic testJumps();
    clearMem();
    mem[0]  = spI(3'd3, 3'd1, 3'd0, 16'd1);
    mem[1]  = spI(3'd1, 3'd1, 3'd0, 16'd0);
    mem[2]  = spI(3'd3, 3'd2, 3'd0, 16'd5);
    mem[3]  = spI(3'd6, 3'd0, 3'd0, 16'h0006);
    mem[4]  = spI(3'd3, 3'd3, 3'd0, 16'h0BAD);
    mem[5]  = spI(3'd3, 3'd3, 3'd0, 16'h0BAD);
    mem[6]  = spI(3'd0, 3'd4, 3'd0, 16'd0);
    mem[7]  = spI(3'd6, 3'd0, 3'd0, 16'h0004);
    mem[8]  = spI(3'd3, 3'd5, 3'd0, 16'h0077);
    mem[9]  = spI(3'd5, 3'd0, 3'd0, 16'hFF0C);
    mem[10] = spI(3'd3, 3'd6, 3'd0, 16'h0BAD);
    mem[11] = spI(3'd3, 3'd6, 3'd0, 16'h0BAD);
    doReset();
    run(4);
    check("R9", "jmpz taken, flag kept by mov (R10)", 32'(imemAddr), 32'd6);
    run(2);
    check("R9", "jmpz not taken after inc", 32'(imemAddr), 32'd8);
    run(2);
    check("R8", "jmp uses low byte", 32'(imemAddr), 32'd12);
    run(3);
    checkReg("R9", 3, 16'h0000);
    checkReg("R8", 6, 16'h0000);
    checkReg("R8", 5, 16'h0077);
    checkReg("R6", 4, 16'h0001);
    checkReg("R7", 2, 16'h0005);
  endtask

  task automatic testIgnored();
    clearMem();
    mem[0]  = spI(3'd3, 3'd1, 3'd0, 16'h0055);
    mem[1]  = riI(3'd1, 3'd3, 3'd1, 16'h0055);
    mem[2]  = {2'b11, 3'd0, 3'd3, 3'd1, 16'h1234};
    mem[3]  = rrI(3'd7, 3'd3, 3'd1, 3'd1);
    mem[4]  = riI(3'd7, 3'd3, 3'd1, 16'h00FF);
    mem[5]  = spI(3'd7, 3'd3, 3'd1, 16'h0AAA);
    mem[6]  = spI(3'd2, 3'd3, 3'd1, 16'h0777);
    mem[7]  = spI(3'd6, 3'd0, 3'd0, 16'd20);
    mem[20] = riI(3'd0, 3'd2, 3'd1, 16'd1);
    mem[21] = spI(3'd6, 3'd0, 3'd0, 16'd30);
    doReset();
    run(8);
    check("R11", "flag survives ignored words", 32'(imemAddr), 32'd20);
    checkReg("R11", 3, 16'h0000);
    checkReg("R11", 1, 16'h0055);
    checkReg("R11", 2, 16'h0000);
    run(2);
    check("R10", "nonzero result clears flag", 32'(imemAddr), 32'd22);
    checkReg("R4", 2, 16'h0056);
  endtask

  task automatic testWrap();
    clearMem();
    doReset();
    run(255);
    check("R2", "address 255 reached", 32'(imemAddr), 32'd255);
    run(1);
    check("R2", "wrap to 0", 32'(imemAddr), 32'd0);
    checkReg("R11", 7, 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clearMem();
    testReset();
    testImm();
    testRegReg();
    testSpecial();
    testJumps();
    testIgnored();
    testWrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule